// File: doc/BRIEF.md
# Duty-Cycle Clock Suspend Modulator

This block slows a processor down by driving an active-low suspend output in a repeating pattern. It holds the output asserted for a programmed number of time ticks, then releases it for a second programmed number, and repeats. The processor idles while the output is low and runs while it is high, so the effective speed is the full speed times the released count divided by the sum of both counts. A prescaler derives the tick from the system clock. The default divider gives 32 µs at 33 MHz.

Software programs the block through a byte-wide register port. Two activity inputs, one for interrupts and one for video, each restart a millisecond speedup timer. While either timer is running, the suspend output stays released, so interrupt service and display updates run at full speed. A new asserted or released count is picked up only at the next phase boundary. A phase that is already running always completes.

Top module: `susp_mod_top`

## Requirements
- R1: After reset every register reads 0x00 and `susp_n` is high.
- R2: A write is visible on `rdata` from the next cycle at the same address. The addresses are 0x80 (power-management enable), 0x8C (interrupt speedup reload), 0x8D (video speedup reload), 0x94 (released count), 0x95 (asserted count) and 0x96 (configuration). Any other address reads 0x00 and ignores writes.
- R3: With modulation active and both counts nonzero, `susp_n` is low for exactly ON×TICK_DIV cycles and then high for exactly OFF×TICK_DIV cycles, repeating. No cycle is lost between phases.
- R4: Modulation is active only while bit 0 of 0x80 and bit 0 of 0x96 are both 1. Otherwise `susp_n` returns high within two cycles and stays high.
- R5: A count of zero skips its phase. ON=0 with OFF>0 keeps `susp_n` high. OFF=0 with ON>0 keeps `susp_n` low without a break.
- R6: With both counts zero, `susp_n` stays high.
- R7: A count written while a phase is running does not change that phase. It applies from the next phase of that kind.
- R8: An `irq_act` pulse sampled while bit 3 of 0x80 is set loads the interrupt timer from 0x8C. `susp_n` is then high for exactly reload×MS_DIV cycles. A later pulse reloads the timer.
- R9: A `vid_act` pulse sampled while bit 4 of 0x80 is set loads the video timer from 0x8D, with the same timing as R8.
- R10: An activity pulse arriving while its enable bit is clear has no effect on `susp_n`.
- R11: `susp_n` only falls at a tick boundary or when a speedup timer expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq_act | input | 1 | Interrupt activity pulse |
| vid_act | input | 1 | Video activity pulse |
| susp_n | output | 1 | Active-low suspend output |

## Verification
The bench runs the sequencer with two asymmetric settings, 3/2 and 1/4, and measures every low and high run to the cycle. This separates an off-by-one tick from swapped ON and OFF counts. It rewrites the asserted count in the middle of a low phase, which shows whether a running phase is cut short or the new value is applied early. Zero-count settings check that phases are skipped and not run for 256 ticks. Single and retriggered speedup pulses, on each input and with enable bits set and clear, distinguish reload from accumulation and check the per-source gating.

// File: rtl/susp_pkg.sv
package susp_pkg;

    localparam logic [7:0] A_PMEN       = 8'h80;
    localparam logic [7:0] A_IRQ_RELOAD = 8'h8C;
    localparam logic [7:0] A_VID_RELOAD = 8'h8D;
    localparam logic [7:0] A_OFF        = 8'h94;
    localparam logic [7:0] A_ON         = 8'h95;
    localparam logic [7:0] A_CFG        = 8'h96;

    localparam int PM_GLOBAL = 0;
    localparam int PM_IRQ    = 3;
    localparam int PM_VID    = 4;
    localparam int CFG_MOD   = 0;

    localparam int N_SPD = 2;

    typedef enum logic [1:0] {PH_IDLE, PH_ON, PH_OFF} phase_e;

    typedef struct packed {
        logic [7:0] pmen;
        logic [7:0] irq_reload;
        logic [7:0] vid_reload;
        logic [7:0] off_len;
        logic [7:0] on_len;
        logic [7:0] cfg;
    } regs_t;

    typedef struct packed {
        phase_e     ph;
        logic [7:0] len;
    } step_t;

    // Choose the phase that follows; zero-length phases are skipped.
    function automatic step_t pick_next(input logic from_on,
                                        input logic [7:0] on_len,
                                        input logic [7:0] off_len);
        step_t s;
        s.ph  = PH_IDLE;
        s.len = '0;
        if (from_on) begin
            if (off_len != 8'd0) begin
                s.ph = PH_OFF; s.len = off_len;
            end else if (on_len != 8'd0) begin
                s.ph = PH_ON;  s.len = on_len;
            end
        end else begin
            if (on_len != 8'd0) begin
                s.ph = PH_ON;  s.len = on_len;
            end else if (off_len != 8'd0) begin
                s.ph = PH_OFF; s.len = off_len;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/susp_div.sv
module susp_div #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic pulse
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign pulse = (cnt == LAST) && !clr;
endmodule

// File: rtl/susp_regs.sv
module susp_regs
    import susp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output regs_t      q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_PMEN:       q.pmen       <= wdata;
                A_IRQ_RELOAD: q.irq_reload <= wdata;
                A_VID_RELOAD: q.vid_reload <= wdata;
                A_OFF:        q.off_len    <= wdata;
                A_ON:         q.on_len     <= wdata;
                A_CFG:        q.cfg        <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_PMEN:       rdata = q.pmen;
            A_IRQ_RELOAD: rdata = q.irq_reload;
            A_VID_RELOAD: rdata = q.vid_reload;
            A_OFF:        rdata = q.off_len;
            A_ON:         rdata = q.on_len;
            A_CFG:        rdata = q.cfg;
            default:      rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/susp_seq.sv
module susp_seq
    import susp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       active,
    input  logic [7:0] on_len,
    input  logic [7:0] off_len,
    output logic       in_on
);
    phase_e     ph;
    logic [7:0] rem;
    step_t      nxt;

    // The counts are sampled only here, at a boundary.
    always_comb nxt = pick_next(ph == PH_ON, on_len, off_len);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            ph  <= PH_IDLE;
            rem <= '0;
        end else if (tick) begin
            if (ph == PH_IDLE || rem == 8'd1) begin
                ph  <= nxt.ph;
                rem <= nxt.len;
            end else begin
                rem <= rem - 1'b1;
            end
        end
    end

    assign in_on = (ph == PH_ON);
endmodule

// File: rtl/susp_spdup.sv
module susp_spdup #(
    parameter int unsigned MS_DIV = 33000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic       act,
    input  logic [7:0] reload,
    output logic       busy
);
    logic       load;
    logic       ms_pulse;
    logic [7:0] remain;

    assign load = act && arm;

    susp_div #(.DIV(MS_DIV)) u_ms (
        .clk  (clk),
        .rst  (rst),
        .clr  (load),
        .pulse(ms_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= reload;
        else if (ms_pulse && remain != 8'd0)
            remain <= remain - 1'b1;
    end

    assign busy = arm && (remain != 8'd0);
endmodule

// File: rtl/susp_mod_top.sv
module susp_mod_top
    import susp_pkg::*;
#(
    parameter int unsigned TICK_DIV = 1056,
    parameter int unsigned MS_DIV   = 33000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       irq_act,
    input  logic       vid_act,
    output logic       susp_n
);
    regs_t            regs_q;
    logic             tick;
    logic             active;
    logic             in_on;
    logic [N_SPD-1:0] spd_act;
    logic [N_SPD-1:0] spd_arm;
    logic [N_SPD-1:0] spd_busy;
    logic [7:0]       spd_load [N_SPD];
    logic             busy_any;

    susp_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata),
        .q    (regs_q)
    );

    susp_div #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (1'b0),
        .pulse(tick)
    );

    assign active = regs_q.pmen[PM_GLOBAL] && regs_q.cfg[CFG_MOD];

    susp_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .active (active),
        .on_len (regs_q.on_len),
        .off_len(regs_q.off_len),
        .in_on  (in_on)
    );

    assign spd_act     = {vid_act, irq_act};
    assign spd_arm     = {regs_q.pmen[PM_VID], regs_q.pmen[PM_IRQ]};
    assign spd_load[0] = regs_q.irq_reload;
    assign spd_load[1] = regs_q.vid_reload;

    for (genvar g = 0; g < N_SPD; g++) begin : g_spd
        susp_spdup #(.MS_DIV(MS_DIV)) u_spd (
            .clk   (clk),
            .rst   (rst),
            .arm   (spd_arm[g]),
            .act   (spd_act[g]),
            .reload(spd_load[g]),
            .busy  (spd_busy[g])
        );
    end

    assign busy_any = |spd_busy;
    assign susp_n   = !(in_on && !busy_any);
endmodule

// File: rtl/susp_chk.sv
module susp_chk (
    input logic       clk,
    input logic       rst,
    input logic       susp_n,
    input logic       act,
    input logic       tick,
    input logic       busy,
    input logic       wr_en,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] off_q,
    input logic [7:0] pm_q,
    input logic [7:0] irq_q,
    input logic       irq_act
);
    // R4
    gate_release_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(act) |-> susp_n);

    // R8
    irq_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(irq_act && pm_q[3] && irq_q != 8'd0) |-> susp_n);

    // R11
    fall_align_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(susp_n) |-> ($past(tick) || $past(busy)));

    // R2
    wr_visible_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && addr == 8'h94) |-> (off_q == $past(wdata)));
endmodule

bind susp_mod_top susp_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .susp_n (susp_n),
    .act    (active),
    .tick   (tick),
    .busy   (busy_any),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .off_q  (regs_q.off_len),
    .pm_q   (regs_q.pmen),
    .irq_q  (regs_q.irq_reload),
    .irq_act(irq_act)
);

// File: tb/susp_mod_top_tb_top.sv
module susp_mod_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TD = 4;
    localparam int MD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_act = 1'b0;
    logic       vid_act = 1'b0;
    logic       susp_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    susp_mod_top #(.TICK_DIV(TD), .MS_DIV(MD)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_act(irq_act), .vid_act(vid_act), .susp_n(susp_n)
    );

    typedef struct {
        logic  lvl;
        int    len;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   skip_runs = 0;
    int   run_len = 0;
    logic prev_lvl = 1'b1;
    bit   done = 0;

    // Monitor: measure each completed run of susp_n and compare with the queue head.
    always @(negedge clk) begin
        if (!rst) begin
            if (susp_n === prev_lvl) begin
                run_len++;
            end else begin
                if (skip_runs > 0) begin
                    skip_runs--;
                end else if (exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (prev_lvl !== e.lvl || run_len != e.len) begin
                        errors++;
                        $display("FAIL %s: run level %0b len %0d, expected level %0b len %0d",
                                 e.req, prev_lvl, run_len, e.lvl, e.len);
                    end
                end
                run_len = 1;
            end
            prev_lvl = susp_n;
        end
    end

    task automatic push(input logic lvl, input int len, input string req);
        exp_t e;
        e.lvl = lvl; e.len = len; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic chk(input string req, input int got, input int expv);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input int expv, input string req);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, int'(rdata), expv);
    endtask

    task automatic hold_chk(input logic lvl, input int cycles, input string req);
        int bad = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (susp_n !== lvl) bad++;
        end
        chk(req, bad, 0);
    endtask

    task automatic drain(input int limit, input string req);
        int n = 0;
        while (exp_q.size() != 0 && n < limit) begin
            @(posedge clk);
            n++;
        end
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL %s: %0d runs missing, expected 0", req, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic pulse(input bit video);
        @(negedge clk);
        if (video) vid_act = 1'b1; else irq_act = 1'b1;
        @(negedge clk);
        vid_act = 1'b0; irq_act = 1'b0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        chk("R1 susp_n", int'(susp_n), 1);
        rd_chk(8'h80, 0, "R1 pmen");
        rd_chk(8'h8C, 0, "R1 irq reload");
        rd_chk(8'h8D, 0, "R1 vid reload");
        rd_chk(8'h94, 0, "R1 off");
        rd_chk(8'h95, 0, "R1 on");
        rd_chk(8'h96, 0, "R1 cfg");

        // R2 readback and unmapped address
        wr(8'h8C, 8'h02); wr(8'h8D, 8'h03); wr(8'h94, 8'hA5); wr(8'h95, 8'h5A);
        wr(8'h00, 8'hFF);
        rd_chk(8'h8C, 8'h02, "R2 irq reload");
        rd_chk(8'h8D, 8'h03, "R2 vid reload");
        rd_chk(8'h94, 8'hA5, "R2 off");
        rd_chk(8'h95, 8'h5A, "R2 on");
        rd_chk(8'h00, 0, "R2 unmapped");
        chk("R2 idle output", int'(susp_n), 1);

        // R3 pattern 3/2
        wr(8'h94, 8'd2); wr(8'h95, 8'd3); wr(8'h80, 8'h01);
        hold_chk(1'b1, 20, "R4 cfg clear");
        skip_runs = 1;
        push(1'b0, 3*TD, "R3 on 3"); push(1'b1, 2*TD, "R3 off 2");
        push(1'b0, 3*TD, "R3 on 3"); push(1'b1, 2*TD, "R3 off 2");
        wr(8'h96, 8'h01);
        drain(300, "R3 3/2");

        // R7 rewrite ON during a running low phase
        push(1'b0, 3*TD, "R7 running on"); push(1'b1, 2*TD, "R7 off");
        push(1'b0, 5*TD, "R7 new on");     push(1'b1, 2*TD, "R7 off");
        wr(8'h95, 8'd5);
        drain(300, "R7");

        // R4 disable via cfg
        wr(8'h96, 8'h00);
        repeat (2) @(negedge clk);
        hold_chk(1'b1, 40, "R4 cfg off");

        // R3 pattern 1/4
        wr(8'h94, 8'd4); wr(8'h95, 8'd1);
        skip_runs = 1;
        push(1'b0, 1*TD, "R3 on 1"); push(1'b1, 4*TD, "R3 off 4");
        push(1'b0, 1*TD, "R3 on 1"); push(1'b1, 4*TD, "R3 off 4");
        wr(8'h96, 8'h01);
        drain(300, "R3 1/4");

        // R4 global enable clear
        wr(8'h80, 8'h00);
        repeat (2) @(negedge clk);
        hold_chk(1'b1, 40, "R4 pm off");
        wr(8'h80, 8'h01);

        // R5 zero OFF: continuous low
        wr(8'h94, 8'd0); wr(8'h95, 8'd2);
        repeat (30) @(negedge clk);
        hold_chk(1'b0, 40, "R5 off zero");
        // R5 zero ON: continuous high
        wr(8'h95, 8'd0); wr(8'h94, 8'd3);
        repeat (30) @(negedge clk);
        hold_chk(1'b1, 40, "R5 on zero");
        // R6 both zero
        wr(8'h94, 8'd0);
        repeat (30) @(negedge clk);
        hold_chk(1'b1, 40, "R6 both zero");

        // R8 interrupt speedup
        wr(8'h95, 8'd2);
        wr(8'h80, 8'h09);
        repeat (30) @(negedge clk);
        skip_runs = 1;
        push(1'b1, 2*MD, "R8 single");
        pulse(1'b0);
        drain(200, "R8 single");
        repeat (10) @(negedge clk);
        skip_runs = 1;
        push(1'b1, 3*MD, "R8 retrigger");
        pulse(1'b0);
        repeat (MD - 2) @(negedge clk);
        pulse(1'b0);
        drain(200, "R8 retrigger");

        // R10 pulses with enable bits clear
        wr(8'h80, 8'h01);
        repeat (5) @(negedge clk);
        pulse(1'b0);
        hold_chk(1'b0, 30, "R10 irq gated");
        pulse(1'b1);
        hold_chk(1'b0, 40, "R10 vid gated");

        // R9 video speedup
        wr(8'h80, 8'h11);
        repeat (5) @(negedge clk);
        skip_runs = 1;
        push(1'b1, 3*MD, "R9 video");
        pulse(1'b1);
        drain(200, "R9 video");

        wr(8'h96, 8'h00);
        repeat (5) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule